// File: doc/BRIEF.md
# Column Edge Histogram Peak Locator

This block watches a binary edge stream, one pixel per cycle with its column and row coordinates, and builds a histogram of edge pixels per image column over one frame. When the frame is over, it scans the histogram and reports the column holding the most edge pixels, together with that column's count. In a track-inspection pipeline this column marks where the rail surface lies in the picture, and later stages crop around it.

Each column's counter sits in a small RAM that is updated by read-modify-write. The update of the pixel just before is forwarded to the one that follows, so a stream may hit the same column on consecutive cycles. No separate clearing pass is needed: the pixel on row 0 of a column writes its own edge value (0 or 1) over whatever the previous frame left. After an end-of-frame flag, the block spends a fixed number of cycles draining and scanning. During that time it ignores its inputs. Then it pulses done for one cycle with the result, and holds the result until the next frame's result replaces it.

Top module: `colPeakFinder`

## Requirements
- R1: A valid pixel with `pixY == 0` sets its column's count to its edge value (1 if `pixEdge` is 1, else 0), discarding the previous frame's count, so each frame's result depends only on that frame's pixels.
- R2: A valid pixel with `pixY != 0` adds 1 to its column's count when `pixEdge` is 1 and leaves the count unchanged when `pixEdge` is 0; cycles with `pixValid` low change nothing.
- R3: A column count saturates at 2^CNT_W-1 (15 with defaults) and never wraps.
- R4: Pixels of the same column on consecutive cycles all take effect; no increment is lost.
- R5: A valid pixel whose `pixX` is COLS or larger has no effect on any count.
- R6: The reported column is the one with the largest count; among equal counts the lowest column index is reported, and `peakCount` equals that column's count.
- R7: `frameEnd` sampled high while the block is accepting starts processing; `peakDone` is high for exactly one cycle, COLS+2 clock edges after the edge that sampled `frameEnd`.
- R8: `peakCol` and `peakCount` change only on the edge that raises `peakDone`, and they hold their values between results.
- R9: From the edge that samples `frameEnd` up to and including the edge that raises `peakDone`, `pixValid` and `frameEnd` are ignored.
- R10: After reset `peakDone`, `peakCol` and `peakCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel present this cycle |
| pixEdge | input | 1 | Binary edge value of the pixel (1 = edge) |
| pixX | input | X_W | Column coordinate of the pixel |
| pixY | input | Y_W | Row coordinate of the pixel |
| frameEnd | input | 1 | Last cycle of the frame (may accompany the last pixel) |
| peakCol | output | $clog2(COLS) | Column with the largest edge count |
| peakCount | output | CNT_W | Edge count of that column |
| peakDone | output | 1 | One-cycle pulse when a new result is presented |

## Verification
The assertions assume that the row-0 pixel of each column comes before any other pixel of that column within a frame, and that a new frame starts only after the previous result has appeared. Outside those conditions the histogram contents are not defined, although the counters still never wrap. The stimulus follows these rules in both row-major and column-major orders, with and without idle gaps. It sends out-of-range columns and deliberately drives junk pixels and extra end-of-frame flags only while the block is busy, where the block is required to ignore them.

// File: rtl/colpk_pkg.sv
package colpk_pkg;

  // Control phases of the locator.
  typedef enum logic [1:0] {
    ST_ACCEPT = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SCAN   = 2'd2,
    ST_FINISH = 2'd3
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic acceptEn;   // pixel stream may update the histogram
    logic scanRd;     // histogram read for the peak scan
    logic scanFirst;  // first scan address
    logic scanLast;   // final scan address
  } strb_t;

endpackage

// File: rtl/colPeakCtrl.sv
module colPeakCtrl
  import colpk_pkg::*;
#(
  parameter int COLS   = 16,
  parameter int COL_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEnd,
  output strb_t             strb,
  output logic [COL_AW-1:0] scanAddr
);

  localparam logic [COL_AW-1:0] LAST_ADDR = COL_AW'(COLS - 1);

  phase_e            state;
  logic [COL_AW-1:0] scanCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_ACCEPT;
      scanCnt <= '0;
    end else begin
      case (state)
        ST_ACCEPT: if (frameEnd) state <= ST_DRAIN;
        ST_DRAIN: begin
          state   <= ST_SCAN;
          scanCnt <= '0;
        end
        ST_SCAN: begin
          if (scanCnt == LAST_ADDR) state <= ST_FINISH;
          else scanCnt <= scanCnt + 1'b1;
        end
        default: state <= ST_ACCEPT;
      endcase
    end
  end

  always_comb begin
    strb.acceptEn  = (state == ST_ACCEPT);
    strb.scanRd    = (state == ST_SCAN);
    strb.scanFirst = (state == ST_SCAN) && (scanCnt == '0);
    strb.scanLast  = (state == ST_SCAN) && (scanCnt == LAST_ADDR);
    scanAddr       = scanCnt;
  end

  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanLast |=> !strb.scanRd); // R7
  AST_FRAME_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptEn && frameEnd) |=> !strb.acceptEn); // R9

endmodule

// File: rtl/colPeakData.sv
module colPeakData
  import colpk_pkg::*;
#(
  parameter int COLS   = 16,
  parameter int COL_AW = 4,
  parameter int X_W    = 5,
  parameter int Y_W    = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [COL_AW-1:0] scanAddr,
  input  logic              pixValid,
  input  logic              pixEdge,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  output logic [COL_AW-1:0] peakCol,
  output logic [CNT_W-1:0]  peakCount,
  output logic              peakDone
);

  localparam int               DEPTH   = 1 << COL_AW;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  histMem [DEPTH];
  logic [CNT_W-1:0]  rdData;
  logic [COL_AW-1:0] rdAddr;
  logic              takePix;

  // Update pipeline stage (pixel waiting for its read data).
  logic              s2Valid, s2Edge, s2First;
  logic [COL_AW-1:0] s2Col;
  // Most recent write, kept for forwarding.
  logic              lastWrValid;
  logic [COL_AW-1:0] lastWrCol;
  logic [CNT_W-1:0]  lastWrData;
  logic [CNT_W-1:0]  baseVal, newVal;

  // Scan compare stage.
  logic              cmpValid, cmpFirst, cmpLast;
  logic [COL_AW-1:0] cmpIdx;
  logic [COL_AW-1:0] bestCol, candCol;
  logic [CNT_W-1:0]  bestCnt, candCnt;
  logic              takeCand;

  assign takePix = strb.acceptEn && pixValid && (int'(pixX) < COLS);
  assign rdAddr  = strb.scanRd ? scanAddr : pixX[COL_AW-1:0];

  // Single synchronous read port, shared by update and scan.
  always_ff @(posedge clk) begin
    rdData <= histMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Edge  <= 1'b0;
      s2First <= 1'b0;
      s2Col   <= '0;
    end else begin
      s2Valid <= takePix;
      s2Edge  <= pixEdge;
      s2First <= (pixY == '0);
      s2Col   <= pixX[COL_AW-1:0];
    end
  end

  // Forward the previous write when it hits the same column.
  always_comb begin
    if (lastWrValid && (lastWrCol == s2Col)) baseVal = lastWrData;
    else baseVal = rdData;
    if (s2First) newVal = {{(CNT_W-1){1'b0}}, s2Edge};
    else if (s2Edge && (baseVal != CNT_MAX)) newVal = baseVal + 1'b1;
    else newVal = baseVal;
  end

  always_ff @(posedge clk) begin
    if (s2Valid) histMem[s2Col] <= newVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWrValid <= 1'b0;
      lastWrCol   <= '0;
      lastWrData  <= '0;
    end else begin
      lastWrValid <= s2Valid;
      lastWrCol   <= s2Col;
      lastWrData  <= newVal;
    end
  end

  // Peak scan: strict greater-than keeps the lowest index on ties.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpFirst <= 1'b0;
      cmpLast  <= 1'b0;
      cmpIdx   <= '0;
    end else begin
      cmpValid <= strb.scanRd;
      cmpFirst <= strb.scanFirst;
      cmpLast  <= strb.scanLast;
      cmpIdx   <= scanAddr;
    end
  end

  always_comb begin
    takeCand = cmpFirst || (rdData > bestCnt);
    candCol  = takeCand ? cmpIdx : bestCol;
    candCnt  = takeCand ? rdData : bestCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestCol   <= '0;
      bestCnt   <= '0;
      peakCol   <= '0;
      peakCount <= '0;
      peakDone  <= 1'b0;
    end else begin
      peakDone <= 1'b0;
      if (cmpValid) begin
        bestCol <= candCol;
        bestCnt <= candCnt;
        if (cmpLast) begin
          peakCol   <= candCol;
          peakCount <= candCnt;
          peakDone  <= 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (s2Valid && !s2First) |-> (newVal >= baseVal)); // R3
  AST_FWD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (s2Valid && !s2First && lastWrValid && (lastWrCol == s2Col)) |-> (newVal >= lastWrData)); // R4
  AST_SCAN_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> !s2Valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    peakDone |=> !peakDone); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !peakDone |-> ($stable(peakCol) && $stable(peakCount))); // R8

endmodule

// File: rtl/colPeakFinder.sv
module colPeakFinder
  import colpk_pkg::*;
#(
  parameter int COLS  = 16,
  parameter int X_W   = 5,
  parameter int Y_W   = 5,
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pixValid,
  input  logic                     pixEdge,
  input  logic [X_W-1:0]           pixX,
  input  logic [Y_W-1:0]           pixY,
  input  logic                     frameEnd,
  output logic [$clog2(COLS)-1:0]  peakCol,
  output logic [CNT_W-1:0]         peakCount,
  output logic                     peakDone
);

  localparam int COL_AW = $clog2(COLS);

  strb_t             strb;
  logic [COL_AW-1:0] scanAddr;

  colPeakCtrl #(.COLS(COLS), .COL_AW(COL_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd),
    .strb(strb), .scanAddr(scanAddr)
  );

  colPeakData #(.COLS(COLS), .COL_AW(COL_AW), .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .scanAddr(scanAddr),
    .pixValid(pixValid), .pixEdge(pixEdge), .pixX(pixX), .pixY(pixY),
    .peakCol(peakCol), .peakCount(peakCount), .peakDone(peakDone)
  );

endmodule

// File: tb/sim_colPeakFinder.sv
`timescale 1ns/1ps
module sim_colPeakFinder;

  localparam int COLS    = 16;
  localparam int X_W     = 5;
  localparam int Y_W     = 5;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  typedef struct {
    int    col;
    int    cnt;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0, pixEdge = 1'b0, frameEnd = 1'b0;
  logic [X_W-1:0] pixX = '0;
  logic [Y_W-1:0] pixY = '0;
  logic [$clog2(COLS)-1:0] peakCol;
  logic [CNT_W-1:0] peakCount;
  logic peakDone;

  int tests = 0;
  int fails = 0;
  item_t expQ[$];
  bit havePrev = 1'b0;
  int prevCol = 0, prevCnt = 0;

  always #4 clk = ~clk;

  colPeakFinder #(.COLS(COLS), .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixEdge(pixEdge),
    .pixX(pixX), .pixY(pixY), .frameEnd(frameEnd),
    .peakCol(peakCol), .peakCount(peakCount), .peakDone(peakDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit edgeOf(input int pat, input int x, input int y);
    case (pat)
      0: return (x == 7) || (((3 * x + y) % 7) == 0);
      1: return ((x == 4) || (x == 11)) && (y < 5);
      2: return 1'b0;
      3: return (x == 9) || ((x == 2) && (y < 12));
      4: return (x == 13) || ((x == 1) && ((y % 2) == 0));
      5: return (x >= COLS) || ((x == 3) && (y < 2));
      6: return ((x == 15) && (y < 2)) || ((x == 6) && (y < 3));
      default: return 1'b0;
    endcase
  endfunction

  // Monitor: compares each presented result with the scoreboard head.
  always @(negedge clk) begin
    if (rstN && peakDone) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9/R7 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(int'(peakCol) == it.col, {it.tag, " R6 column"}, int'(peakCol), it.col);
        check(int'(peakCount) == it.cnt, {it.tag, " R6 count"}, int'(peakCount), it.cnt);
      end
    end
  end

  // Driver: builds the expected histogram, pushes the result, drives the frame.
  task automatic sendFrame(input int pat, input int rows, input bit colMajor,
                           input bit gaps, input bit junk, input string tag);
    int expCnt[COLS];
    int xr, total, idx, lat, bestC, bestN;
    item_t it;
    xr = (pat == 5) ? 32 : COLS;
    for (int c = 0; c < COLS; c++) expCnt[c] = 0;
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < COLS; x++)
        if (edgeOf(pat, x, y) && expCnt[x] < CNT_MAX) expCnt[x]++;
    bestC = 0; bestN = expCnt[0];
    for (int c = 1; c < COLS; c++)
      if (expCnt[c] > bestN) begin bestC = c; bestN = expCnt[c]; end
    it.col = bestC; it.cnt = bestN; it.tag = tag;
    expQ.push_back(it);

    total = rows * xr;
    idx = 0;
    for (int a = 0; a < (colMajor ? xr : rows); a++) begin
      for (int b = 0; b < (colMajor ? rows : xr); b++) begin
        int x, y;
        x = colMajor ? a : b;
        y = colMajor ? b : a;
        if (gaps && (idx % 3) == 2) begin
          @(negedge clk);
          pixValid = 1'b0; frameEnd = 1'b0;
        end
        @(negedge clk);
        if (idx == total - 1 && havePrev) begin
          check(int'(peakCol) == prevCol, {tag, " R8 column held"}, int'(peakCol), prevCol);
          check(int'(peakCount) == prevCnt, {tag, " R8 count held"}, int'(peakCount), prevCnt);
        end
        pixValid = 1'b1;
        pixEdge  = edgeOf(pat, x, y);
        pixX     = X_W'(x);
        pixY     = Y_W'(y);
        frameEnd = (idx == total - 1);
        idx++;
      end
    end
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      if (peakDone || lat > COLS + 20) break;
      if (junk) begin
        pixValid = 1'b1; pixEdge = 1'b1;
        pixX = X_W'(15); pixY = Y_W'(3);
        frameEnd = lat[0];
      end else begin
        pixValid = 1'b0; frameEnd = 1'b0;
      end
      lat++;
    end
    pixValid = 1'b0; frameEnd = 1'b0; pixEdge = 1'b0;
    check(lat == COLS + 2, {tag, " R7 latency"}, lat, COLS + 2);
    havePrev = 1'b1; prevCol = bestC; prevCnt = bestN;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(peakDone == 1'b0, "R10 done after reset", int'(peakDone), 0);
    check(peakCol == '0, "R10 column after reset", int'(peakCol), 0);
    check(peakCount == '0, "R10 count after reset", int'(peakCount), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(peakDone == 1'b0, "R10 idle without frame", int'(peakDone), 0);

    sendFrame(0, 10, 1'b0, 1'b1, 1'b0, "R2 mixed edges with gaps");
    sendFrame(1, 8,  1'b0, 1'b0, 1'b0, "R6 tie lowest index");
    sendFrame(2, 6,  1'b0, 1'b0, 1'b0, "R1 empty frame clears");
    sendFrame(3, 20, 1'b0, 1'b0, 1'b0, "R3 saturation");
    sendFrame(4, 10, 1'b1, 1'b0, 1'b0, "R4 same column back-to-back");
    sendFrame(5, 4,  1'b0, 1'b0, 1'b0, "R5 out-of-range columns");
    sendFrame(6, 6,  1'b0, 1'b0, 1'b1, "R9 busy inputs ignored");
    sendFrame(0, 10, 1'b0, 1'b0, 1'b0, "R1 repeat frame no carry-over");

    repeat (COLS + 10) @(negedge clk);
    check(expQ.size() == 0, "R7 every frame reported", expQ.size(), 0);
    finishRun();
  end

endmodule